// File: doc/BRIEF.md
# GPS Self-Test Signal Generator

This block makes a synthetic front-end sample stream for one correlator channel, so that the channel can be exercised without a radio. It builds a C/A spreading code from two 10-stage linear feedback shift registers. It reads the top three bits of an externally supplied carrier phase word and turns them into a sign bit and a magnitude bit. While test mode is on, these two bits replace the real sign and magnitude samples at the channel input. While test mode is off, the real samples pass through unchanged.

The code rate comes from a half-chip strobe supplied by an external code NCO. After a restart, a programmed number of half-chip strobes is consumed before the code starts to move. From then on, every second strobe advances the code by one chip. A pair of G2 tap positions selects which satellite code is produced. A test-data bit sets the polarity of the pattern: it is XORed with the current chip.

Top module: `gps_selftest_gen`

## Requirements
- R1: When `test_en_i` is 0, `sign_o` equals `fe_sign_i` and `mag_o` equals `fe_mag_i`. When it is 1, both outputs come from the generator.
- R2: A cycle with `restart_i` high sets both LFSRs to all ones, the chip index to 0 and the half-chip phase to 0, and loads `slew_i` into the slew counter. `restart_i` takes priority over a strobe in the same cycle. Reset gives the same state with a slew of 0.
- R3: While the slew counter is nonzero, each `half_tick_i` strobe decrements it and the code does not advance. A slew of N therefore delays the code by N half chips.
- R4: Once the slew counter is zero, the code advances by one chip on every second `half_tick_i` strobe.
- R5: The chip is G1 stage 10 XOR G2[`tap_a_i`] XOR G2[`tap_b_i`], with stages numbered 1 to 10. The feedback polynomials are G1 = 1+x^3+x^10 and G2 = 1+x^2+x^3+x^6+x^8+x^9+x^10. With taps (2,6), the first ten chips are 1100100000. With taps (3,7), they are 1110010000.
- R6: After 1023 chips, both registers reload to all ones. `epoch_o` is high for exactly one cycle, in the cycle after the strobe that completes chip 1022.
- R7: The octant is `carrier_phase_i[PHASE_W-1 -: 3]`. The generated sign is octant bit 2 XOR `test_data_i` XOR chip, which makes it high in 4 of the 8 octants.
- R8: The generated magnitude is high only in octants 0 and 4, which is 2 of the 8 octants.
- R9: While `test_en_i` is 0, `half_tick_i` strobes are ignored: the slew counter, the half-chip phase and the code all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Selects the generated samples instead of the front end |
| restart_i | input | 1 | Restarts the code and loads the slew count |
| slew_i | input | SLEW_W | Start delay, counted in half chips |
| tap_a_i | input | 4 | First G2 tap position (1 to 10) |
| tap_b_i | input | 4 | Second G2 tap position (1 to 10) |
| half_tick_i | input | 1 | Half-chip strobe from the code NCO |
| carrier_phase_i | input | PHASE_W | Carrier NCO phase word |
| test_data_i | input | 1 | Polarity bit, XORed with the chip |
| fe_sign_i | input | 1 | Real front-end sign sample |
| fe_mag_i | input | 1 | Real front-end magnitude sample |
| sign_o | output | 1 | Sign sample sent to the channel |
| mag_o | output | 1 | Magnitude sample sent to the channel |
| epoch_o | output | 1 | One-cycle pulse when the code wraps |

## Verification
The assertions check several rules on every cycle:
- a restart leaves both registers at all ones;
- the code never moves while slew remains;
- G1 never reaches the all-zero lock-up state;
- an epoch pulse coincides with chip index 0;
- magnitude is asserted only in octants 0 and 4.

Only the bench scenarios can show the rules that need a whole sequence. These are the actual chip sequences for two tap pairs, the exact strobe count at which a slewed code first changes, the 1023-chip wrap with a repeat of the opening chips, and that strobes given in bypass leave the code unmoved.

// File: rtl/gps_st_pkg.sv
package gps_st_pkg;
  localparam int unsigned CA_LEN = 1023;
  localparam int unsigned IDX_W  = $clog2(CA_LEN);

  typedef logic [10:1] lfsr_t;

  // feedback masks over stages 10..1
  localparam lfsr_t G1_MASK = 10'b10_0000_0100;
  localparam lfsr_t G2_MASK = 10'b11_1010_0110;
  localparam lfsr_t ALL_ONE = '1;

  function automatic lfsr_t lfsr_step(lfsr_t s, lfsr_t mask);
    return {s[9:1], ^(s & mask)};
  endfunction
endpackage

// File: rtl/gps_st_slew.sv
module gps_st_slew #(
  parameter int unsigned SLEW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [SLEW_W-1:0] slew_i,
  input  logic              tick_i,
  output logic              adv_o
);
  logic [SLEW_W-1:0] slew_q;
  logic              half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slew_q <= '0;
      half_q <= 1'b0;
    end else if (restart_i) begin
      slew_q <= slew_i;
      half_q <= 1'b0;
    end else if (tick_i) begin
      if (slew_q != '0) slew_q <= slew_q - 1'b1;
      else              half_q <= ~half_q;
    end
  end

  assign adv_o = tick_i && !restart_i && (slew_q == '0) && half_q;

  p_no_adv_in_slew_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slew_q != '0) |-> !adv_o);
  p_half_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(half_q) && $stable(slew_q));
endmodule

// File: rtl/gps_st_ca_gen.sv
module gps_st_ca_gen
  import gps_st_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       adv_i,
  input  logic [3:0] tap_a_i,
  input  logic [3:0] tap_b_i,
  output logic       chip_o,
  output logic       epoch_o
);
  lfsr_t            g1_q, g2_q;
  logic [IDX_W-1:0] idx_q;
  logic             epoch_q;
  logic [10:1]      hit_a, hit_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g1_q    <= ALL_ONE;
      g2_q    <= ALL_ONE;
      idx_q   <= '0;
      epoch_q <= 1'b0;
    end else begin
      epoch_q <= 1'b0;
      if (restart_i) begin
        g1_q  <= ALL_ONE;
        g2_q  <= ALL_ONE;
        idx_q <= '0;
      end else if (adv_i) begin
        if (idx_q == IDX_W'(CA_LEN - 1)) begin
          g1_q    <= ALL_ONE;
          g2_q    <= ALL_ONE;
          idx_q   <= '0;
          epoch_q <= 1'b1;
        end else begin
          g1_q  <= lfsr_step(g1_q, G1_MASK);
          g2_q  <= lfsr_step(g2_q, G2_MASK);
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // tap pick, out-of-range taps contribute 0
  for (genvar i = 1; i <= 10; i++) begin : g_tap
    assign hit_a[i] = (tap_a_i == 4'(i)) & g2_q[i];
    assign hit_b[i] = (tap_b_i == 4'(i)) & g2_q[i];
  end

  assign chip_o  = g1_q[10] ^ (|hit_a) ^ (|hit_b);
  assign epoch_o = epoch_q;

  p_restart_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (g1_q == ALL_ONE) && (g2_q == ALL_ONE) && (idx_q == '0));
  p_g1_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g1_q != '0);
  p_epoch_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_q |-> (idx_q == '0) && (g1_q == ALL_ONE));
  p_hold_no_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !restart_i) |=> $stable(g1_q) && $stable(idx_q));
endmodule

// File: rtl/gps_st_octant_map.sv
module gps_st_octant_map #(
  parameter int unsigned PHASE_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               pol_i,
  output logic               sign_o,
  output logic               mag_o
);
  logic [2:0] oct;
  assign oct    = phase_i[PHASE_W-1 -: 3];
  assign sign_o = oct[2] ^ pol_i;
  assign mag_o  = (oct[1:0] == 2'b00);

  p_mag_octant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_o |-> (phase_i[PHASE_W-2 -: 2] == 2'b00));
endmodule

// File: rtl/gps_selftest_gen.sv
module gps_selftest_gen #(
  parameter int unsigned SLEW_W  = 8,
  parameter int unsigned PHASE_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               test_en_i,
  input  logic               restart_i,
  input  logic [SLEW_W-1:0]  slew_i,
  input  logic [3:0]         tap_a_i,
  input  logic [3:0]         tap_b_i,
  input  logic               half_tick_i,
  input  logic [PHASE_W-1:0] carrier_phase_i,
  input  logic               test_data_i,
  input  logic               fe_sign_i,
  input  logic               fe_mag_i,
  output logic               sign_o,
  output logic               mag_o,
  output logic               epoch_o
);
  logic tick, adv, chip, gen_sign, gen_mag;

  assign tick = half_tick_i & test_en_i;

  gps_st_slew #(.SLEW_W(SLEW_W)) u_slew (
    .clk_i, .rst_ni, .restart_i, .slew_i, .tick_i(tick), .adv_o(adv)
  );

  gps_st_ca_gen u_ca (
    .clk_i, .rst_ni, .restart_i, .adv_i(adv), .tap_a_i, .tap_b_i,
    .chip_o(chip), .epoch_o
  );

  gps_st_octant_map #(.PHASE_W(PHASE_W)) u_map (
    .clk_i, .rst_ni, .phase_i(carrier_phase_i), .pol_i(test_data_i ^ chip),
    .sign_o(gen_sign), .mag_o(gen_mag)
  );

  assign sign_o = test_en_i ? gen_sign : fe_sign_i;
  assign mag_o  = test_en_i ? gen_mag  : fe_mag_i;

  p_bypass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |-> (sign_o == fe_sign_i) && (mag_o == fe_mag_i));
endmodule

// File: tb/gps_selftest_gen_tb.sv
module gps_selftest_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLEW_W  = 8;
  localparam int PHASE_W = 10;

  // {octant[2:0], test_data, exp_sign, exp_mag}, chip = 1 after restart
  localparam logic [5:0] VEC [16] = '{
    6'b000_0_1_1, 6'b000_1_0_1, 6'b001_0_1_0, 6'b001_1_0_0,
    6'b010_0_1_0, 6'b010_1_0_0, 6'b011_0_1_0, 6'b011_1_0_0,
    6'b100_0_0_1, 6'b100_1_1_1, 6'b101_0_0_0, 6'b101_1_1_0,
    6'b110_0_0_0, 6'b110_1_1_0, 6'b111_0_0_0, 6'b111_1_1_0
  };
  localparam logic [9:0] PRN_26 = 10'b1100100000;
  localparam logic [9:0] PRN_37 = 10'b1110010000;

  logic clk_i = 0, rst_ni = 0;
  logic test_en_i = 0, restart_i = 0, half_tick_i = 0, test_data_i = 0;
  logic fe_sign_i = 0, fe_mag_i = 0;
  logic [SLEW_W-1:0] slew_i = '0;
  logic [3:0] tap_a_i = 4'd2, tap_b_i = 4'd6;
  logic [PHASE_W-1:0] carrier_phase_i = '0;
  logic sign_o, mag_o, epoch_o;
  int total = 0, bad = 0, epochs = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gps_selftest_gen #(.SLEW_W(SLEW_W), .PHASE_W(PHASE_W)) u_dut (.*);

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i) half_tick_i = 1;
    @(negedge clk_i) half_tick_i = 0;
    epochs += int'(epoch_o);
  endtask

  task automatic restart(logic [SLEW_W-1:0] s);
    @(negedge clk_i) begin restart_i = 1; slew_i = s; end
    @(negedge clk_i) restart_i = 0;
  endtask

  task automatic check_seq(string req, logic [9:0] exp);
    for (int k = 9; k >= 0; k--) begin
      check(req, sign_o, exp[k]);
      tick(); tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // reset state: bypass, then chip 1 in octant 0
    fe_sign_i = 1; fe_mag_i = 0;
    @(negedge clk_i);
    check("R1 reset bypass sign", sign_o, 1'b1);
    check("R1 reset bypass mag", mag_o, 1'b0);
    check("R6 reset epoch", epoch_o, 1'b0);
    fe_sign_i = 0; fe_mag_i = 1;
    @(negedge clk_i);
    check("R1 bypass sign", sign_o, 1'b0);
    check("R1 bypass mag", mag_o, 1'b1);

    // decode table, R7 R8
    test_en_i = 1;
    for (int i = 0; i < 16; i++) begin
      carrier_phase_i = {VEC[i][5:3], 7'h55};
      test_data_i = VEC[i][2];
      @(negedge clk_i);
      check("R7 sign decode", sign_o, VEC[i][1]);
      check("R8 mag decode", mag_o, VEC[i][0]);
    end
    carrier_phase_i = '0; test_data_i = 0;

    // R5 code sequences
    restart(0);
    check_seq("R5 taps 2,6", PRN_26);
    tap_a_i = 4'd3; tap_b_i = 4'd7;
    restart(0);
    check_seq("R5 taps 3,7", PRN_37);
    tap_a_i = 4'd2; tap_b_i = 4'd6;

    // R2 R3 R4 slew timing: chip2 = 0
    restart(3);
    check("R2 restart chip0", sign_o, 1'b1);
    repeat (6) tick();
    check("R3 slew still before chip2", sign_o, 1'b1);
    tick();
    check("R3 slew chip2 at strobe 7", sign_o, 1'b0);
    restart(0);
    repeat (3) tick();
    check("R4 no slew before chip2", sign_o, 1'b1);
    tick();
    check("R4 chip2 at strobe 4", sign_o, 1'b0);

    // R2 restart wins over strobe
    @(negedge clk_i) begin restart_i = 1; half_tick_i = 1; slew_i = 0; end
    @(negedge clk_i) begin restart_i = 0; half_tick_i = 0; end
    tick(); tick(); tick();
    check("R2 restart priority", sign_o, 1'b1);

    // R9 strobes ignored in bypass
    restart(0);
    test_en_i = 0;
    repeat (8) tick();
    test_en_i = 1;
    @(negedge clk_i);
    check_seq("R9 no advance in bypass", PRN_26);

    // R6 period
    restart(0);
    epochs = 0;
    repeat (2045) tick();
    check("R6 no epoch before wrap", epochs != 0, 1'b0);
    tick();
    check("R6 one epoch at wrap", epochs == 1, 1'b1);
    @(negedge clk_i);
    check("R6 epoch one cycle", epoch_o, 1'b0);
    check_seq("R6 sequence repeats", PRN_26);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule